// File: doc/BRIEF.md
# Bidirectional Loadable Shift Register

This block is a small register, four bits wide by default, that changes state only on the rising clock edge. At every edge it performs exactly one action, chosen by a fixed priority. A synchronous clear comes first. A parallel capture of a data word comes next. Otherwise the register moves its contents by one position, left or right as a direction select chooses, and a serial input bit fills the position that is vacated.

The block has no hold mode. While clear and load are both low, the register shifts on every edge. The output comes straight from the register flops, so no input reaches it through combinational logic. Datapaths use the block for serial-to-parallel conversion, for rotating or stepping a pattern under a controller, and for presetting a word and then shifting it out one bit at a time.

Top module: `bidir_shift_reg`

## Requirements
- R1: The output changes only at a rising clock edge. An input change between edges leaves the output unchanged until the next rising edge.
- R2: When `sync_clr` is 1 at an edge, the register becomes all zeros, whatever the values of `load_en`, `go_left`, `ser_in` and `par_in`.
- R3: When `sync_clr` is 0 and `load_en` is 1 at an edge, the register captures `par_in`. This happens whatever the values of `go_left` and `ser_in`.
- R4: When `sync_clr` and `load_en` are both 0 and `go_left` is 1, the register shifts left. The new value is the old bits [W-2:0] followed by `ser_in` in bit 0, and the old bit W-1 is dropped. For W=4 the new value is (2*old + ser_in) mod 16.
- R5: When `sync_clr` and `load_en` are both 0 and `go_left` is 0, the register shifts right. The new value is `ser_in` in bit W-1 followed by the old bits [W-1:1], and the old bit 0 is dropped. For W=4 the new value is floor(old/2) + 8*ser_in.
- R6: Exactly one of clear, load, left shift or right shift takes effect at every edge. The register is never held unchanged by its control logic.
- R7: The width W is a parameter with a default of 4, and all behaviour above scales with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| sync_clr | input | 1 | Synchronous clear, highest priority |
| load_en | input | 1 | Parallel capture of `par_in`, second priority |
| par_in | input | W | Parallel data word |
| ser_in | input | 1 | Bit shifted into the vacated end |
| go_left | input | 1 | Direction: 1 shifts left, 0 shifts right |
| q_out | output | W | Register contents |

## Verification
Clear, load and shift can all be requested at the same edge, so the priority between them is the main matter to cover. The bench first loads each of the sixteen possible register values. It then applies all sixteen combinations of `sync_clr`, `load_en`, `go_left` and `ser_in` in one edge. Each result is compared with a value the bench computes by arithmetic. The comparison shows that clear beats load, that load beats either shift, and that `par_in` is ignored during a clear. A separate step changes the inputs between edges and confirms that the output does not move.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Action selected for one clock edge.
  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_LEFT  = 2'd2,
    ACT_RIGHT = 2'd3
  } bsr_act_e;

  // Priority decode: clear, then load, then a shift in the chosen direction.
  function automatic bsr_act_e pick_action(input logic clr, input logic ld,
                                           input logic left);
    if (clr)       return ACT_CLEAR;
    else if (ld)   return ACT_LOAD;
    else if (left) return ACT_LEFT;
    else           return ACT_RIGHT;
  endfunction

  // One-hot view of an action, ordered {right, left, load, clear}.
  function automatic logic [3:0] act_to_mask(input bsr_act_e a);
    return 4'b0001 << a;
  endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic       clk,
  input  logic       sync_clr,
  input  logic       load_en,
  input  logic       go_left,
  output bsr_act_e   act,
  output logic [3:0] act_mask
);

  always_comb begin
    act      = pick_action(sync_clr, load_en, go_left);
    act_mask = act_to_mask(act);
  end

  // R6: exactly one action is chosen at every edge
  a_r6_one_action: assert property (@(posedge clk) disable iff (sync_clr)
    $countones(act_mask) == 1);

  // R2: a clear request always wins, even over load
  a_r2_clear_wins: assert property (@(posedge clk)
    sync_clr |-> act_mask[0] && !act_mask[1]);

endmodule

// File: rtl/bsr_next.sv
module bsr_next #(
  parameter int W = 4
) (
  input  logic [3:0]   act_mask,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] nxt
);

  localparam int TOP = W - 1;

  // Per-bit selection: each bit picks among zero, its parallel bit,
  // its lower neighbour (left shift) or its upper neighbour (right shift).
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_lsb
      assign from_below = ser_in;
    end else begin : g_mid_lo
      assign from_below = cur[i-1];
    end
    if (i == TOP) begin : g_msb
      assign from_above = ser_in;
    end else begin : g_mid_hi
      assign from_above = cur[i+1];
    end
    always_comb begin
      unique case (1'b1)
        act_mask[1]: nxt[i] = par_in[i];
        act_mask[2]: nxt[i] = from_below;
        act_mask[3]: nxt[i] = from_above;
        default:     nxt[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         sync_clr,
  input  logic         load_en,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  input  logic         go_left,
  output logic [W-1:0] q_out
);

  localparam logic [W-1:0] ZERO = '0;

  bsr_act_e       act;
  logic [3:0]     act_mask;
  logic [W-1:0]   state_q;
  logic [W-1:0]   state_d;

  bsr_ctrl u_ctrl (
    .clk      (clk),
    .sync_clr (sync_clr),
    .load_en  (load_en),
    .go_left  (go_left),
    .act      (act),
    .act_mask (act_mask)
  );

  bsr_next #(.W(W)) u_next (
    .act_mask (act_mask),
    .cur      (state_q),
    .par_in   (par_in),
    .ser_in   (ser_in),
    .nxt      (state_d)
  );

  // R1, R7: all state lives in one W-bit register updated only at the edge
  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  assign q_out = state_q;

  // R2: clear yields zero at the next edge
  a_r2_clear: assert property (@(posedge clk)
    sync_clr |=> q_out == ZERO);

  // R3: load captures the parallel word
  a_r3_load: assert property (@(posedge clk) disable iff (sync_clr)
    load_en |=> q_out == $past(par_in));

  // R4: left shift brings the serial bit into bit 0
  a_r4_left: assert property (@(posedge clk) disable iff (sync_clr)
    (!load_en && go_left) |=>
      q_out == {$past(q_out[W-2:0]), $past(ser_in)});

  // R5: right shift brings the serial bit into the top bit
  a_r5_right: assert property (@(posedge clk) disable iff (sync_clr)
    (!load_en && !go_left) |=>
      q_out == {$past(ser_in), $past(q_out[W-1:1])});

  // R6: the decoded action is consistent with the priority inputs
  a_r6_act_sel: assert property (@(posedge clk) disable iff (sync_clr)
    (!load_en) |-> (act == ACT_LEFT || act == ACT_RIGHT));

endmodule

// File: tb/bidir_shift_reg_test.sv
module bidir_shift_reg_test;

  logic       clk = 1'b0;
  logic       sync_clr = 1'b1;
  logic       load_en = 1'b0;
  logic [3:0] par_in = 4'd0;
  logic       ser_in = 1'b0;
  logic       go_left = 1'b0;
  logic [3:0] q_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bidir_shift_reg #(.W(4)) uut (
    .clk      (clk),
    .sync_clr (sync_clr),
    .load_en  (load_en),
    .par_in   (par_in),
    .ser_in   (ser_in),
    .go_left  (go_left),
    .q_out    (q_out)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Reference model from the requirements, by arithmetic.
  function automatic int model(input int cur, input int clr, input int ld,
                               input int par, input int left, input int ser);
    if (clr != 0)  return 0;                      // R2
    if (ld != 0)   return par;                    // R3
    if (left != 0) return (cur * 2 + ser) % 16;   // R4
    return cur / 2 + ser * 8;                     // R5
  endfunction

  task automatic step(input bit c, input bit l, input logic [3:0] p,
                      input bit g, input bit s);
    @(negedge clk);
    sync_clr = c; load_en = l; par_in = p; go_left = g; ser_in = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    step(1'b1, 1'b1, 4'hF, 1'b1, 1'b1);
    check("R2 reset state", int'(q_out), 0);

    // R1: inputs moved between edges must not reach the output
    step(1'b0, 1'b1, 4'hA, 1'b0, 1'b0);
    check("R3 load A", int'(q_out), 10);
    load_en = 1'b1; par_in = 4'h5; sync_clr = 1'b1; ser_in = 1'b1;
    #2;
    check("R1 mid-cycle hold", int'(q_out), 10);
    @(posedge clk); #1;
    check("R1 update at edge", int'(q_out), 0);

    // R7: walking a one through all W positions both ways
    step(1'b0, 1'b1, 4'h1, 1'b0, 1'b0);
    for (int k = 1; k < 4; k++) begin
      step(1'b0, 1'b0, 4'h0, 1'b1, 1'b0);
      check("R7 walk left", int'(q_out), 1 << k);
    end
    step(1'b0, 1'b0, 4'h0, 1'b1, 1'b0);
    check("R4 msb dropped", int'(q_out), 0);
    step(1'b0, 1'b0, 4'h0, 1'b0, 1'b1);
    check("R5 ser into msb", int'(q_out), 8);
    step(1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
    check("R6 shift every edge", int'(q_out), 4);

    // Near-exhaustive sweep: every start value against every control mix
    for (int st = 0; st < 16; st++) begin
      for (int cm = 0; cm < 16; cm++) begin
        int p;
        int exp;
        string tag;
        p = (st * 7 + cm * 5 + 3) % 16;
        step(1'b0, 1'b1, 4'(st), 1'b0, 1'b0);
        check("R3 preset", int'(q_out), st);
        step(cm[3], cm[2], 4'(p), cm[1], cm[0]);
        exp = model(st, cm[3], cm[2], p, cm[1], cm[0]);
        if (cm[3])      tag = "R2 clear priority";
        else if (cm[2]) tag = "R3 load priority";
        else if (cm[1]) tag = "R4 left shift";
        else            tag = "R5 right shift";
        check(tag, int'(q_out), exp);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule